// File: doc/BRIEF.md
# Sync Polarity and Timing Analyzer

This block watches the horizontal and vertical sync lines of an incoming video source, both sampled on the pixel clock. For each sync it works out which level is the active pulse and drives a normalized copy in which the pulse is always high. It also measures the period and the active pulse width of each sync. Horizontal figures are counted in pixel clocks. Vertical figures are counted in lines, where a line is one leading edge of the normalized horizontal sync.

For interlaced sources the block classifies each field by where the vertical leading edge lands inside the current line. If either sync stops toggling, it flags loss of signal. It raises a one-cycle interrupt when a new period measurement moves by more than a tolerance the host sets, or when a loss flag sets. Mode detection firmware reads the held results from the output ports and uses them to identify the video timing.

Both sync inputs pass through a two-flop synchronizer before any measurement. Polarity is decided from one complete period: whichever phase is shorter is taken as the pulse.

Top module: `sync_timing_analyzer`

## Requirements
- R1: For each sync, the active-low flag is 1 when the low phase of the last full period is strictly shorter than the high phase, and 0 otherwise (equal phases count as active-high).
- R2: The normalized outputs `hs_out` and `vs_out` are high exactly during the active phase of their sync, whatever the input polarity.
- R3: `hs_period` is the number of pixel clocks between two rising edges of `hsync_in`, and `hs_width` is the length in clocks of the shorter phase.
- R4: `vs_period` and `vs_width` give the same two figures for the vertical sync, counted in normalized horizontal leading edges (lines).
- R5: At each vertical leading edge, `field_odd` becomes 1 when fewer than `hs_period/2` clocks have passed since the last horizontal leading edge, and 0 otherwise. It holds its value between vertical leading edges.
- R6: When a sync stays in one phase for more than 2^W−1 samples, where W is that sync's counter width, its lost flag sets and the phase counter saturates. The next edge on that sync clears the flag.
- R7: `irq` pulses for one cycle when a newly published period differs from the previous one by more than `tol`; the first period after reset is compared against 0. It also pulses when either lost flag sets. A period change within `tol` raises no pulse.
- R8: While `rst` is high, and in the cycle after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, either polarity |
| vsync_in | input | 1 | Raw vertical sync, either polarity |
| tol | input | TOL_W | Period change tolerance for the interrupt |
| hs_out | output | 1 | Horizontal sync, normalized to active-high |
| vs_out | output | 1 | Vertical sync, normalized to active-high |
| hs_act_low | output | 1 | Horizontal sync detected as active-low |
| vs_act_low | output | 1 | Vertical sync detected as active-low |
| hs_period | output | HS_W | Horizontal period in clocks |
| hs_width | output | HS_W | Horizontal pulse width in clocks |
| vs_period | output | VS_W | Vertical period in lines |
| vs_width | output | VS_W | Vertical pulse width in lines |
| hs_lost | output | 1 | No horizontal edge within counter range |
| vs_lost | output | 1 | No vertical edge within counter range |
| field_odd | output | 1 | Field class of the latest vertical leading edge |
| irq | output | 1 | One-cycle measurement change pulse |

## Verification
The horizontal meter is driven with three patterns: a narrow high pulse, a narrow low pulse, and a 50% square wave. Together they separate correct polarity choice from an inverted or tie-broken-wrong decision, and the count of high cycles on the normalized output confirms that the pulse really is the shorter phase. Three successive period changes, one of zero, one inside the tolerance and one outside it, separate an interrupt comparator that is off by one or sign from a correct one. Vertical frames with an active-low three-line pulse check counting in lines. Interlaced frames that alternate the leading edge between the first and second half of the line tell the two field classes apart. Finally, each sync is frozen past its counter range to show the lost flag setting and then clearing.

// File: rtl/sta_pkg.sv
package sta_pkg;
  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} sync_pol_e;
endpackage

// File: rtl/sta_sync.sv
module sta_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sta_meter.sv
module sta_meter
  import sta_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic          tick,
  output logic          norm,
  output logic          act_low,
  output logic [CW-1:0] period,
  output logic [CW-1:0] width,
  output logic          lost,
  output logic          upd
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          prev, had_fall;
  logic [CW-1:0] cnt, hi_len;
  logic [CW:0]   sum;
  sync_pol_e     pol_next;

  always_comb begin
    sum      = {1'b0, hi_len} + {1'b0, cnt};
    pol_next = (cnt < hi_len) ? POL_LOW : POL_HIGH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0; had_fall <= 1'b0; cnt <= '0; hi_len <= '0;
      norm <= 1'b0; act_low <= 1'b0; period <= '0; width <= '0;
      lost <= 1'b0; upd <= 1'b0;
    end else begin
      upd  <= 1'b0;
      norm <= lvl ^ act_low;
      if (tick) begin
        prev <= lvl;
        if (lvl == prev) begin
          if (cnt != CMAX) cnt <= cnt + 1'b1;
          else             lost <= 1'b1;
        end else begin
          cnt  <= {{(CW-1){1'b0}}, 1'b1};
          lost <= 1'b0;
          if (!lvl) begin
            hi_len   <= cnt;
            had_fall <= 1'b1;
          end else if (had_fall) begin
            period  <= sum[CW] ? CMAX : sum[CW-1:0];
            act_low <= (pol_next == POL_LOW);
            width   <= (pol_next == POL_LOW) ? cnt : hi_len;
            upd     <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  width_le_period_chk: assert property (@(posedge clk) disable iff (rst)
    width <= period);

  // R6
  lost_after_sat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(cnt) == CMAX);

  // R6
  upd_clears_lost_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> !lost);
endmodule

// File: rtl/sta_field.sv
module sta_field #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_rise,
  input  logic          vs_rise,
  input  logic [CW-1:0] hs_period,
  output logic          field_odd
);
  localparam logic [CW-1:0] PMAX = {CW{1'b1}};

  logic [CW-1:0] hpos;

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos      <= '0;
      field_odd <= 1'b0;
    end else begin
      if (hs_rise)           hpos <= '0;
      else if (hpos != PMAX) hpos <= hpos + 1'b1;
      if (vs_rise) field_odd <= (hpos < (hs_period >> 1));
    end
  end

  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(field_odd));
endmodule

// File: rtl/sta_irq.sv
module sta_irq #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tol,
  input  logic          hs_upd,
  input  logic [HW-1:0] hs_period,
  input  logic          vs_upd,
  input  logic [VW-1:0] vs_period,
  input  logic          hs_lost,
  input  logic          vs_lost,
  output logic          irq
);
  logic [HW-1:0] hs_ref;
  logic [VW-1:0] vs_ref;
  logic          hs_lost_d, vs_lost_d;
  logic [31:0]   hd, vd, tl;
  logic          hs_hit, vs_hit;

  always_comb begin
    tl     = 32'(tol);
    hd     = (hs_period >= hs_ref) ? 32'(hs_period - hs_ref) : 32'(hs_ref - hs_period);
    vd     = (vs_period >= vs_ref) ? 32'(vs_period - vs_ref) : 32'(vs_ref - vs_period);
    hs_hit = hs_upd && (hd > tl);
    vs_hit = vs_upd && (vd > tl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_ref <= '0; vs_ref <= '0;
      hs_lost_d <= 1'b0; vs_lost_d <= 1'b0;
      irq <= 1'b0;
    end else begin
      hs_lost_d <= hs_lost;
      vs_lost_d <= vs_lost;
      if (hs_upd) hs_ref <= hs_period;
      if (vs_upd) vs_ref <= vs_period;
      irq <= hs_hit || vs_hit || (hs_lost && !hs_lost_d) || (vs_lost && !vs_lost_d);
    end
  end

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hs_upd || vs_upd || hs_lost || vs_lost));
endmodule

// File: rtl/sync_timing_analyzer.sv
module sync_timing_analyzer #(
  parameter int HS_W  = 12,
  parameter int VS_W  = 11,
  parameter int TOL_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [TOL_W-1:0] tol,
  output logic             hs_out,
  output logic             vs_out,
  output logic             hs_act_low,
  output logic             vs_act_low,
  output logic [HS_W-1:0]  hs_period,
  output logic [HS_W-1:0]  hs_width,
  output logic [VS_W-1:0]  vs_period,
  output logic [VS_W-1:0]  vs_width,
  output logic             hs_lost,
  output logic             vs_lost,
  output logic             field_odd,
  output logic             irq
);
  logic [1:0] raw_s;
  logic       hs_lvl, vs_lvl, hs_d, vs_d, hs_rise, vs_rise, hs_upd, vs_upd;

  sta_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({vsync_in, hsync_in}), .q(raw_s));

  assign hs_lvl = raw_s[0];
  assign vs_lvl = raw_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin hs_d <= 1'b0; vs_d <= 1'b0; end
    else     begin hs_d <= hs_out; vs_d <= vs_out; end
  end

  assign hs_rise = hs_out & ~hs_d;
  assign vs_rise = vs_out & ~vs_d;

  sta_meter #(.CW(HS_W)) u_hs (
    .clk(clk), .rst(rst), .lvl(hs_lvl), .tick(1'b1), .norm(hs_out),
    .act_low(hs_act_low), .period(hs_period), .width(hs_width),
    .lost(hs_lost), .upd(hs_upd));

  sta_meter #(.CW(VS_W)) u_vs (
    .clk(clk), .rst(rst), .lvl(vs_lvl), .tick(hs_rise), .norm(vs_out),
    .act_low(vs_act_low), .period(vs_period), .width(vs_width),
    .lost(vs_lost), .upd(vs_upd));

  sta_field #(.CW(HS_W)) u_field (
    .clk(clk), .rst(rst), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .hs_period(hs_period), .field_odd(field_odd));

  sta_irq #(.HW(HS_W), .VW(VS_W), .TW(TOL_W)) u_irq (
    .clk(clk), .rst(rst), .tol(tol), .hs_upd(hs_upd), .hs_period(hs_period),
    .vs_upd(vs_upd), .vs_period(vs_period), .hs_lost(hs_lost),
    .vs_lost(vs_lost), .irq(irq));

  // R2
  hs_norm_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(hs_lvl) && $stable(hs_act_low)) |=> $stable(hs_out));
endmodule

// File: tb/tb_sync_timing_analyzer.sv
module tb_sync_timing_analyzer;
  localparam int CLK_P = 10;
  localparam int HW = 10, VW = 8, TW = 8;
  localparam int LINE = 40;

  logic clk = 1'b0, rst = 1'b1, hs_i = 1'b0, vs_i = 1'b1;
  logic [TW-1:0] tol = 8'd5;
  logic hs_out, vs_out, hs_al, vs_al, hs_lost, vs_lost, field_odd, irq;
  logic [HW-1:0] hs_period, hs_width;
  logic [VW-1:0] vs_period, vs_width;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, norm_cnt = 0;
  bit cnt_en = 0, sb_on = 0, pend = 0, vs_prev = 0;
  bit exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  sync_timing_analyzer #(.HS_W(HW), .VS_W(VW), .TOL_W(TW)) dut (
    .clk(clk), .rst(rst), .hsync_in(hs_i), .vsync_in(vs_i), .tol(tol),
    .hs_out(hs_out), .vs_out(vs_out), .hs_act_low(hs_al), .vs_act_low(vs_al),
    .hs_period(hs_period), .hs_width(hs_width), .vs_period(vs_period),
    .vs_width(vs_width), .hs_lost(hs_lost), .vs_lost(vs_lost),
    .field_odd(field_odd), .irq(irq));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: interrupt and normalized-pulse counters, field scoreboard
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (cnt_en && hs_out) norm_cnt++;
    vs_prev <= vs_out;
    if (pend) begin
      pend <= 0;
      if (exp_q.size() == 0) chk("R5", "unexpected field edge", 1, 0);
      else chk("R5", "field_odd", field_odd, exp_q.pop_front());
    end
    if (sb_on && vs_out && !vs_prev) pend <= 1;
  end

  task automatic cyc(bit h, bit v);
    hs_i = h; vs_i = v;
    @(negedge clk);
  endtask

  task automatic run_hs(int h, int l, int n);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < h; c++) cyc(1'b1, vs_i);
      for (int c = 0; c < l; c++) cyc(1'b0, vs_i);
    end
  endtask

  task automatic line(bit vb, bit va, int pos);
    for (int c = 0; c < LINE; c++) cyc(c < 4, (c < pos) ? vb : va);
  endtask

  // active-low vertical pulse of w lines, frame of n lines; driver pushes expectation
  task automatic frame(int pos, int w, int n, bit push);
    if (push) exp_q.push_back(pos < LINE/2);
    for (int j = 0; j < n; j++) begin
      if (j == 0)      line(1'b1, 1'b0, pos);
      else if (j == w) line(1'b0, 1'b1, pos);
      else             line(j < w ? 1'b0 : 1'b1, j < w ? 1'b0 : 1'b1, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8", "hs_period in reset", hs_period, 0);
    chk("R8", "outputs in reset", {hs_out, vs_out, hs_al, vs_al, hs_lost, vs_lost, field_odd, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "outputs after release", {hs_out, hs_al, hs_lost, irq, 2'(vs_period)}, 0);

    // R1 R3 narrow high pulse
    run_hs(4, 36, 6);
    chk("R3", "hs_period 4/36", hs_period, 40);
    chk("R3", "hs_width 4/36", hs_width, 4);
    chk("R1", "act_low 4/36", hs_al, 0);
    norm_cnt = 0; cnt_en = 1; run_hs(4, 36, 1); cnt_en = 0;
    chk("R2", "norm high cycles 4/36", norm_cnt, 4);

    // R1 R3 narrow low pulse
    run_hs(36, 4, 6);
    chk("R3", "hs_period 36/4", hs_period, 40);
    chk("R3", "hs_width 36/4", hs_width, 4);
    chk("R1", "act_low 36/4", hs_al, 1);
    norm_cnt = 0; cnt_en = 1; run_hs(36, 4, 1); cnt_en = 0;
    chk("R2", "norm high cycles 36/4", norm_cnt, 4);

    // R1 tie
    run_hs(20, 20, 5);
    chk("R1", "act_low tie", hs_al, 0);
    chk("R3", "hs_width tie", hs_width, 20);

    // R7 tolerance
    run_hs(4, 36, 6);
    irq_cnt = 0; run_hs(4, 36, 5);
    chk("R7", "irq steady", irq_cnt, 0);
    irq_cnt = 0; run_hs(4, 38, 5);
    chk("R7", "irq within tol", irq_cnt, 0);
    chk("R3", "hs_period 42", hs_period, 42);
    irq_cnt = 0; run_hs(4, 50, 5);
    chk("R7", "irq beyond tol", irq_cnt, 1);
    chk("R3", "hs_period 54", hs_period, 54);

    // R6 horizontal loss
    irq_cnt = 0;
    for (int c = 0; c < 1100; c++) cyc(1'b0, vs_i);
    chk("R6", "hs_lost set", hs_lost, 1);
    chk("R7", "irq on loss", irq_cnt, 1);
    run_hs(4, 36, 5);
    chk("R6", "hs_lost cleared", hs_lost, 0);
    chk("R3", "hs_period after loss", hs_period, 40);

    // R4 vertical in lines
    for (int f = 0; f < 3; f++) frame(10, 3, 100, 1'b0);
    chk("R4", "vs_period", vs_period, 100);
    chk("R4", "vs_width", vs_width, 3);
    chk("R1", "vs act_low", vs_al, 1);

    // R5 interlaced field scoreboard
    sb_on = 1;
    frame(10, 3, 100, 1'b1);
    frame(30, 3, 100, 1'b1);
    frame(10, 3, 100, 1'b1);
    frame(30, 3, 100, 1'b1);
    repeat (3) @(negedge clk);
    sb_on = 0;
    chk("R5", "scoreboard drained", exp_q.size(), 0);
    chk("R4", "vs_period interlaced", vs_period, 100);

    // R6 vertical loss
    irq_cnt = 0;
    for (int j = 0; j < 300; j++) line(1'b1, 1'b1, 0);
    chk("R6", "vs_lost set", vs_lost, 1);
    chk("R7", "irq on vs loss", irq_cnt, 1);
    chk("R4", "vs_period held", vs_period, 100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule